// File: doc/BRIEF.md
# Locked Program-Bank Mapper

This block places the CPU program window at $8000-$FFFF onto 256 KB of program ROM. The ROM is built as two 128 KB chips, and the block treats it as sixteen 16 KB banks. Banks 0-7 sit on the first chip and banks 8-15 on the second. An upstream serial loader assembles register writes and hands each one over as a 2-bit register select (CPU address bits 14:13) with a 5-bit value. The block also receives CPU address bits 14:0 and the loader's reset event. It drives the 18-bit ROM address, the nametable mirroring code, a work-RAM enable and an unlocked flag.

After reset the window is frozen on the first 32 KB of the first chip, whatever the registers hold. Bank switching starts only after a control bit has been written low and later written high. Once unlocked, a chip-select bit picks one of two layouts:
- a plain 32 KB page on the first chip;
- one of three layouts on the second chip (a 32 KB page, or a pair of 16 KB halves).

Register writes take effect at the clock edge on which `wr_en` is sampled. The ROM address follows `cpu_addr` combinationally.

Top module: `prg_lock_mapper`

## Requirements
- R1: `rom_addr[13:0]` equals `cpu_addr[13:0]`, and `rom_addr[17:14]` is the selected 16 KB bank number (0-15, where 8-15 are the second chip).
- R2: A write to register 0 (`wr_sel`=0) stores the mirroring code from bits 1:0, the slot bit S from bit 2 and the size bit P from bit 3. `mirror` outputs the code: 0 means one-screen low, 1 means one-screen high, 2 means vertical, 3 means horizontal. Reset gives mirror=2 and S=P=1.
- R3: A write to register 3 (`wr_sel`=3) stores the work-RAM disable bit W from bit 4 and bank B from bits 3:0. `wram_en` is the inverse of W. Reset clears W.
- R4: While locked (after reset and until unlocked), the bank is 0 when `cpu_addr[14]`=0 and 1 when it is 1, whatever any register holds.
- R5: The unlock state starts at 0. A register 1 write with bit 4 (I) = 0 moves state 0 to 1. A later register 1 write with I=1 moves state 1 to 2. No other write changes the state. `unlocked` is high only in state 2 and stays high until reset.
- R6: A register 1 write stores the chip-select bit O from bit 3 and bank A from bits 2:1 (reset 0). When unlocked with O=0, the bank is 2*A + `cpu_addr[14]`.
- R7: When unlocked with O=1 and P=0, the bank is 8 + 2*B[2:1] + `cpu_addr[14]`. B[0] is ignored.
- R8: When unlocked with O=1, P=1 and S=0, the $8000 half (`cpu_addr[14]`=0) is bank 8 and the $C000 half is bank 8+B[2:0].
- R9: When unlocked with O=1, P=1 and S=1, the $8000 half is bank 8+B[2:0] and the $C000 half is bank 15.
- R10: `loader_rst` sets P and S to 1 at the clock edge. This overrides a write to register 0 in the same cycle, but the mirroring code of that write is still stored.
- R11: Writes to register 2 (`wr_sel`=2) change no output.
- R12: B[3] never affects the selected bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Assembled register write strobe |
| wr_sel | input | 2 | Register select (CPU address 14:13) |
| wr_data | input | 5 | Assembled register value |
| loader_rst | input | 1 | Serial-loader reset event |
| cpu_addr | input | 15 | CPU address bits 14:0 |
| rom_addr | output | 18 | Program ROM address |
| mirror | output | 2 | Nametable mirroring code |
| wram_en | output | 1 | Work-RAM access enable |
| unlocked | output | 1 | Bank switching enabled |

## Verification
The unlocked layouts on the second chip are the hardest to reach. They need the ordered I-low then I-high pair on register 1 before any bank register has an effect. The bench therefore first proves the lock by sweeping register contents while locked. It also checks that out-of-order and repeated I writes do not unlock. It then walks the full unlock sequence and sweeps every O, P, S, A and B combination, rewriting register 1 with I=1 so the state is kept. The collision of a loader reset with a register 0 write in the same cycle is driven on purpose.

// File: rtl/prg_lock_mapper.sv
module prg_lock_mapper #(
  parameter int BANK_W = 4,
  parameter int OFFS_W = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_sel,
  input  logic [4:0]                 wr_data,
  input  logic                       loader_rst,
  input  logic [OFFS_W:0]            cpu_addr,
  output logic [BANK_W+OFFS_W-1:0]   rom_addr,
  output logic [1:0]                 mirror,
  output logic                       wram_en,
  output logic                       unlocked
);

  localparam logic [BANK_W-1:0] CHIP2_FIRST = BANK_W'(8);
  localparam logic [BANK_W-1:0] CHIP2_LAST  = BANK_W'(15);

  logic [1:0] mir_q;
  logic       slot_q, size_q, chip_q, wdis_q;
  logic [1:0] bank_a_q;
  logic [2:0] bank_b_q;
  logic [1:0] stage_q;
  logic [BANK_W-1:0] bank;

  wire hi = cpu_addr[OFFS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mir_q    <= 2'd2;
      slot_q   <= 1'b1;
      size_q   <= 1'b1;
      chip_q   <= 1'b0;
      bank_a_q <= 2'd0;
      bank_b_q <= 3'd0;
      wdis_q   <= 1'b0;
      stage_q  <= 2'd0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin
            mir_q  <= wr_data[1:0];
            slot_q <= wr_data[2];
            size_q <= wr_data[3];
          end
          2'd1: begin
            chip_q   <= wr_data[3];
            bank_a_q <= wr_data[2:1];
            if (stage_q == 2'd0 && !wr_data[4])
              stage_q <= 2'd1;
            else if (stage_q == 2'd1 && wr_data[4])
              stage_q <= 2'd2;
          end
          2'd3: begin
            wdis_q   <= wr_data[4];
            bank_b_q <= wr_data[2:0];
          end
          default: ;
        endcase
      end
      if (loader_rst) begin
        slot_q <= 1'b1;
        size_q <= 1'b1;
      end
    end
  end

  assign unlocked = (stage_q == 2'd2);

  always_comb begin
    if (!unlocked)
      bank = BANK_W'(hi);
    else if (!chip_q)
      bank = {1'b0, bank_a_q, hi};
    else if (!size_q)
      bank = {1'b1, bank_b_q[2:1], hi};
    else if (!slot_q)
      bank = hi ? {1'b1, bank_b_q} : CHIP2_FIRST;
    else
      bank = hi ? CHIP2_LAST : {1'b1, bank_b_q};
  end

  assign rom_addr = {bank, cpu_addr[OFFS_W-1:0]};
  assign mirror   = mir_q;
  assign wram_en  = !wdis_q;

endmodule

// File: rtl/prg_lock_mapper_chk.sv
module prg_lock_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [4:0]  wr_data,
  input logic        loader_rst,
  input logic [14:0] cpu_addr,
  input logic [17:0] rom_addr,
  input logic [1:0]  mirror,
  input logic        wram_en,
  input logic        unlocked
);

  // R5
  a_r5_unlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  // R5
  a_r5_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(unlocked));

  // R4
  a_r4_locked_first32k: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (rom_addr[17:15] == 3'd0 && rom_addr[14] == cpu_addr[14]));

  // R3
  a_r3_wram_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> (wram_en == !$past(wr_data[4])));

  // R2
  a_r2_mirror_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (mirror == $past(wr_data[1:0])));

  // R11
  a_r11_reg2_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && !loader_rst) |=> ($stable(mirror) && $stable(wram_en) && $stable(unlocked)));

endmodule

bind prg_lock_mapper prg_lock_mapper_chk u_chk (.*);

// File: tb/prg_lock_mapper_tb.sv
`timescale 1ns/1ps
module prg_lock_mapper_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [4:0]  wr_data = 0;
  logic        loader_rst = 0;
  logic [14:0] cpu_addr = 0;
  logic [17:0] rom_addr;
  logic [1:0]  mirror;
  logic        wram_en;
  logic        unlocked;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_mir, m_s, m_p, m_o, m_a, m_b, m_w, m_st;

  always #5 clk = ~clk;

  prg_lock_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .loader_rst(loader_rst), .cpu_addr(cpu_addr), .rom_addr(rom_addr),
    .mirror(mirror), .wram_en(wram_en), .unlocked(unlocked));

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mir = 2; m_s = 1; m_p = 1; m_o = 0; m_a = 0; m_b = 0; m_w = 0; m_st = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic wr(input int sel, input int d, input bit lr);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 5'(d); loader_rst = lr;
    @(negedge clk);
    wr_en = 0; loader_rst = 0;
    case (sel)
      0: begin m_mir = d % 4; m_s = (d >> 2) & 1; m_p = (d >> 3) & 1; end
      1: begin
        m_o = (d >> 3) & 1; m_a = (d >> 1) & 3;
        if (m_st == 0 && ((d >> 4) & 1) == 0) m_st = 1;
        else if (m_st == 1 && ((d >> 4) & 1) == 1) m_st = 2;
      end
      3: begin m_w = (d >> 4) & 1; m_b = d % 16; end
      default: ;
    endcase
    if (lr) begin m_s = 1; m_p = 1; end
  endtask

  function automatic int exp_bank(input int h, input int b);
    if (m_st != 2) return h;
    if (m_o == 0) return m_a * 2 + h;
    if (m_p == 0) return 8 + ((b % 8) / 2) * 2 + h;
    if (m_s == 0) return h ? 8 + (b % 8) : 8;
    return h ? 15 : 8 + (b % 8);
  endfunction

  task automatic check_all(input string r);
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < 2; k++) begin
        int off = k ? 16'h3FFF : 16'h01A5;
        cpu_addr = 15'(h * 16384 + off);
        #1;
        chk({r, " R1 rom_addr"}, rom_addr, exp_bank(h, m_b) * 16384 + off);
        if (m_b >= 8)
          chk("R12 bank B bit3", rom_addr, exp_bank(h, m_b - 8) * 16384 + off);
      end
    end
    chk({r, " R2 mirror"}, mirror, m_mir);
    chk({r, " R3 wram_en"}, wram_en, 1 - m_w);
    chk({r, " R5 unlocked"}, unlocked, m_st == 2);
  endtask

  function automatic string mode_tag();
    if (m_st != 2) return "R4";
    if (m_o == 0) return "R6";
    if (m_p == 0) return "R7";
    if (m_s == 0) return "R8";
    return "R9";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R4 reset");

    // R4: locked, sweep register contents (I kept high so state stays 0)
    for (int v = 0; v < 32; v++) begin
      wr(0, v, 0);
      wr(1, v | 16, 0);
      wr(3, v, 0);
      check_all("R4 locked sweep");
    end

    // R5: repeated I=0 stays in state 1, other registers do not advance
    wr(1, 0, 0);
    check_all("R5 after I low");
    wr(1, 0, 0);
    wr(0, 31, 0);
    wr(3, 31, 0);
    wr(2, 31, 0);
    check_all("R5 still locked");
    wr(1, 16 | 8 | 6, 0);
    check_all("R5 unlocked");
    wr(1, 6, 0);
    check_all("R5 I low after unlock");

    // R11: register 2 writes have no effect
    for (int v = 0; v < 32; v++) begin
      wr(2, v, 0);
      check_all("R11 reg2 ignored");
    end

    // Unlocked layout sweep (R6 R7 R8 R9 R12)
    for (int o = 0; o < 2; o++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++)
          for (int a = 0; a < 4; a++)
            for (int b = 0; b < 16; b++) begin
              wr(0, p * 8 + s * 4 + ((a + b) % 4), 0);
              wr(1, 16 + o * 8 + a * 2 + (b % 2), 0);
              wr(3, ((b % 3) == 0 ? 16 : 0) + b, 0);
              check_all(mode_tag());
            end

    // R10: loader reset alone, and colliding with a register 0 write
    wr(1, 16 | 8, 0);
    wr(3, 5, 0);
    wr(0, 1, 0);
    check_all("R10 pre R7");
    wr(2, 0, 1);
    check_all("R10 loader reset alone");
    wr(0, 3, 1);
    check_all("R10 collision");
    chk("R10 mirror kept", mirror, 3);

    // R4: reset relocks
    do_reset();
    check_all("R4 relock after reset");
    wr(1, 16, 0);
    wr(1, 0, 0);
    wr(0, 0, 0);
    wr(1, 16 | 8, 0);
    check_all("R5 second unlock");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule